// File: doc/BRIEF.md
# Raw-to-Temperature Linear Converter

This block turns a 12-bit raw reading from an on-die thermal sensor into a signed temperature in millidegrees Celsius. It is a three-stage pipelined fixed-point datapath. Each valid raw value enters together with a sensor index and a configuration word. The configuration word holds a mode select, an offset, a scale and a signed deviation. Exactly three clock edges later a valid pulse leaves with the 32-bit result.

Two conversion laws are available. The linear law subtracts one tenth of raw × scale from the offset. The piecewise law takes its slope and intercept from fixed constants, and which pair it uses depends on the raw value and on the sensor index. Both laws end by adding the deviation, which sits outside the calibrated formula. A raw value of zero means the sensor has not yet produced a sample. For that value the block reports "no data" and gives no temperature.

The configuration is captured in the same cycle as the raw value, so a stream may mix modes and constants cycle by cycle.

Top module: `temp_lin_conv`

## Requirements
- R1: With `cfg_mode` = 0 (linear), the result is `cfg_offset - (raw * cfg_scale) / 10 + cfg_dev`. The division truncates toward zero, and the arithmetic is two's complement at 32 bits. Offset 217000 with scale 1211 and offset 187744 with scale 672 must both convert correctly.
- R2: `cfg_dev` is a signed value added after the formula in both modes. Deviations such as +7000, +8000 and negative values give the formula result shifted by exactly that amount.
- R3: With `cfg_mode` = 1 (piecewise) and raw ≥ 0x500, the result is `223000 - (raw * 1191) / 10 + cfg_dev`, whatever the sensor index. In this mode `cfg_offset` and `cfg_scale` are ignored.
- R4: With `cfg_mode` = 1, raw < 0x500 and sensor index 0, the result is `259000 - (raw * 1452) / 10 + cfg_dev`.
- R5: With `cfg_mode` = 1, raw < 0x500 and any nonzero sensor index, the result is `276000 - (raw * 1590) / 10 + cfg_dev`.
- R6: A raw value of 0 produces an output pulse with `out_no_data` = 1 and `out_temp` = 0 in either mode. `out_no_data` is never 1 without `out_valid`.
- R7: Latency is exactly three clock edges. Every cycle with `in_valid` = 1 yields exactly one `out_valid` pulse, and no pulse appears otherwise. Back-to-back inputs with different modes, ids and raw values come out in order, each converted with the configuration presented alongside it.
- R8: While `rst_n` is low, and after it is released until the first result arrives, `out_valid`, `out_no_data` and `out_temp` are all 0.
- R9: Intermediate products do not overflow for any 12-bit raw value and any 16-bit scale. With raw 0xFFF, scale 0xFFFF, offset 0 and deviation 0, the result is -26836582.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample and configuration are present |
| in_raw | input | 12 | Raw sensor reading |
| in_id | input | 2 | Sensor index |
| cfg_mode | input | 1 | 0 = linear law, 1 = piecewise law |
| cfg_offset | input | 32 | Signed linear-mode offset, millidegrees |
| cfg_scale | input | 16 | Unsigned linear-mode scale, tenths |
| cfg_dev | input | 32 | Signed deviation added after the formula |
| out_valid | output | 1 | Result pulse |
| out_temp | output | 32 | Signed temperature, millidegrees |
| out_no_data | output | 1 | Raw value was zero; no temperature |

## Verification
Two choices can fall on the same coefficient-select cycle: the segment threshold at 0x500 and the sensor-index choice. Directed samples at 0x4FF and 0x500 with index 0 and a nonzero index show which coefficient pair won. A second concurrency is a zero raw value streamed back-to-back between real conversions while the mode flips every cycle. The bench drives four consecutive inputs and compares each output against its own expected value and its own no-data flag in the cycle three edges later.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic {
    MODE_LINEAR    = 1'b0,
    MODE_PIECEWISE = 1'b1
  } conv_mode_e;

  localparam int SCALE_DIV  = 10;

  // piecewise law constants
  localparam int PW_KNEE    = 'h500;
  localparam int PW_HI_K    = 1191;
  localparam int PW_HI_OFF  = 223000;
  localparam int PW_LO0_K   = 1452;
  localparam int PW_LO0_OFF = 259000;
  localparam int PW_LO1_K   = 1590;
  localparam int PW_LO1_OFF = 276000;

endpackage

// File: rtl/tc_coef_sel.sv
module tc_coef_sel
  import tc_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int ID_W  = 2,
  parameter int K_W   = 16,
  parameter int OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [RAW_W-1:0]        in_raw,
  input  logic [ID_W-1:0]         in_id,
  input  logic                    cfg_mode,
  input  logic signed [OUT_W-1:0] cfg_offset,
  input  logic [K_W-1:0]          cfg_scale,
  input  logic signed [OUT_W-1:0] cfg_dev,
  output logic                    s1_valid,
  output logic [RAW_W-1:0]        s1_raw,
  output logic [K_W-1:0]          s1_k,
  output logic signed [OUT_W-1:0] s1_off,
  output logic signed [OUT_W-1:0] s1_dev,
  output logic                    s1_nodata
);

  conv_mode_e              mode;
  logic [K_W-1:0]          k_d;
  logic signed [OUT_W-1:0] off_d;
  logic                    nodata_d;

  assign mode = conv_mode_e'(cfg_mode);

  // coefficient choice: knee first, then sensor index
  always_comb begin
    k_d      = cfg_scale;
    off_d    = cfg_offset;
    nodata_d = (in_raw == '0);
    if (mode == MODE_PIECEWISE) begin
      if (in_raw >= RAW_W'(PW_KNEE)) begin
        k_d   = K_W'(PW_HI_K);
        off_d = OUT_W'(PW_HI_OFF);
      end else if (in_id == '0) begin
        k_d   = K_W'(PW_LO0_K);
        off_d = OUT_W'(PW_LO0_OFF);
      end else begin
        k_d   = K_W'(PW_LO1_K);
        off_d = OUT_W'(PW_LO1_OFF);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_raw    <= '0;
      s1_k      <= '0;
      s1_off    <= '0;
      s1_dev    <= '0;
      s1_nodata <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_raw    <= in_raw;
        s1_k      <= k_d;
        s1_off    <= off_d;
        s1_dev    <= cfg_dev;
        s1_nodata <= nodata_d;
      end
    end
  end

endmodule

// File: rtl/tc_mult.sv
module tc_mult #(
  parameter int RAW_W = 12,
  parameter int K_W   = 16,
  parameter int OUT_W = 32,
  localparam int PROD_W = RAW_W + K_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic [RAW_W-1:0]        s1_raw,
  input  logic [K_W-1:0]          s1_k,
  input  logic signed [OUT_W-1:0] s1_off,
  input  logic signed [OUT_W-1:0] s1_dev,
  input  logic                    s1_nodata,
  output logic                    s2_valid,
  output logic [PROD_W-1:0]       s2_prod,
  output logic signed [OUT_W-1:0] s2_off,
  output logic signed [OUT_W-1:0] s2_dev,
  output logic                    s2_nodata
);

  logic [PROD_W-1:0] prod_d;

  // full-width unsigned product, no truncation possible
  always_comb begin
    prod_d = PROD_W'(s1_raw) * PROD_W'(s1_k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_prod   <= '0;
      s2_off    <= '0;
      s2_dev    <= '0;
      s2_nodata <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_prod   <= prod_d;
        s2_off    <= s1_off;
        s2_dev    <= s1_dev;
        s2_nodata <= s1_nodata;
      end
    end
  end

  // R6
  nodata_zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_nodata) |-> (s2_prod == '0));

endmodule

// File: rtl/tc_finish.sv
module tc_finish
  import tc_pkg::*;
#(
  parameter int PROD_W = 28,
  parameter int OUT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s2_valid,
  input  logic [PROD_W-1:0]       s2_prod,
  input  logic signed [OUT_W-1:0] s2_off,
  input  logic signed [OUT_W-1:0] s2_dev,
  input  logic                    s2_nodata,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_temp,
  output logic                    out_no_data
);

  localparam int PAD_W = OUT_W - PROD_W;

  logic [PROD_W-1:0]       quo;
  logic signed [OUT_W-1:0] quo_s;
  logic signed [OUT_W-1:0] temp_d;

  // product is non-negative, so floor equals truncation toward zero
  always_comb begin
    quo    = s2_prod / PROD_W'(SCALE_DIV);
    quo_s  = signed'({{PAD_W{1'b0}}, quo});
    temp_d = s2_nodata ? '0 : (s2_off - quo_s + s2_dev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_temp    <= '0;
      out_no_data <= 1'b0;
    end else begin
      out_valid   <= s2_valid;
      out_no_data <= s2_valid & s2_nodata;
      if (s2_valid) begin
        out_temp <= temp_d;
      end
    end
  end

  // R6
  nodata_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_no_data |-> out_valid);

endmodule

// File: rtl/temp_lin_conv.sv
module temp_lin_conv #(
  parameter int RAW_W = 12,
  parameter int ID_W  = 2,
  parameter int K_W   = 16,
  parameter int OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [RAW_W-1:0]        in_raw,
  input  logic [ID_W-1:0]         in_id,
  input  logic                    cfg_mode,
  input  logic signed [OUT_W-1:0] cfg_offset,
  input  logic [K_W-1:0]          cfg_scale,
  input  logic signed [OUT_W-1:0] cfg_dev,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_temp,
  output logic                    out_no_data
);

  localparam int PROD_W = RAW_W + K_W;
  localparam int LAT    = 3;

  logic                    s1_valid, s1_nodata;
  logic [RAW_W-1:0]        s1_raw;
  logic [K_W-1:0]          s1_k;
  logic signed [OUT_W-1:0] s1_off, s1_dev;
  logic                    s2_valid, s2_nodata;
  logic [PROD_W-1:0]       s2_prod;
  logic signed [OUT_W-1:0] s2_off, s2_dev;

  tc_coef_sel #(.RAW_W(RAW_W), .ID_W(ID_W), .K_W(K_W), .OUT_W(OUT_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_raw(in_raw), .in_id(in_id),
    .cfg_mode(cfg_mode), .cfg_offset(cfg_offset),
    .cfg_scale(cfg_scale), .cfg_dev(cfg_dev),
    .s1_valid(s1_valid), .s1_raw(s1_raw), .s1_k(s1_k),
    .s1_off(s1_off), .s1_dev(s1_dev), .s1_nodata(s1_nodata)
  );

  tc_mult #(.RAW_W(RAW_W), .K_W(K_W), .OUT_W(OUT_W)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_raw(s1_raw), .s1_k(s1_k),
    .s1_off(s1_off), .s1_dev(s1_dev), .s1_nodata(s1_nodata),
    .s2_valid(s2_valid), .s2_prod(s2_prod),
    .s2_off(s2_off), .s2_dev(s2_dev), .s2_nodata(s2_nodata)
  );

  tc_finish #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_fin (
    .clk(clk), .rst_n(rst_n),
    .s2_valid(s2_valid), .s2_prod(s2_prod),
    .s2_off(s2_off), .s2_dev(s2_dev), .s2_nodata(s2_nodata),
    .out_valid(out_valid), .out_temp(out_temp), .out_no_data(out_no_data)
  );

  // cycles since reset, saturating, so $past never reaches before reset
  logic [1:0] age_q, age_d;
  always_comb begin
    age_d = (age_q == 2'(LAT)) ? age_q : age_q + 2'd1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  // R7
  lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'(LAT) && $past(in_valid, 3)) |-> out_valid);

  // R7
  lat_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'(LAT) && out_valid) |-> $past(in_valid, 3));

  // R8
  early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'(LAT)) |-> !out_valid);

  // R6
  nodata_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_no_data) |-> (out_temp == '0));

endmodule

// File: tb/tb_temp_lin_conv.sv
module tb_temp_lin_conv;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic [11:0]        in_raw;
  logic [1:0]         in_id;
  logic               cfg_mode;
  logic signed [31:0] cfg_offset;
  logic [15:0]        cfg_scale;
  logic signed [31:0] cfg_dev;
  logic               out_valid;
  logic signed [31:0] out_temp;
  logic               out_no_data;

  int n_checks = 0;
  int n_fails  = 0;

  temp_lin_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .in_id(in_id), .cfg_mode(cfg_mode), .cfg_offset(cfg_offset),
    .cfg_scale(cfg_scale), .cfg_dev(cfg_dev), .out_valid(out_valid),
    .out_temp(out_temp), .out_no_data(out_no_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic signed [31:0] model(bit pw, longint off, longint sc,
                                               longint dev, int raw, int id);
    longint k, o;
    if (raw == 0) return 32'sd0;
    if (pw) begin
      if (raw >= 'h500)  begin k = 1191; o = 223000; end
      else if (id == 0)  begin k = 1452; o = 259000; end
      else               begin k = 1590; o = 276000; end
    end else begin
      k = sc; o = off;
    end
    return 32'(o - (longint'(raw) * k) / 10 + dev);
  endfunction

  task automatic check(string req, bit ok, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // single conversion with pipeline empty before and after
  task automatic convert(string req, int raw, int id);
    logic signed [31:0] exp_t;
    bit exp_nd;
    exp_t  = model(cfg_mode, cfg_offset, cfg_scale, cfg_dev, raw, id);
    exp_nd = (raw == 0);
    in_valid = 1'b1; in_raw = 12'(raw); in_id = 2'(id);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 early", out_valid == 1'b0, out_valid, 0);
    @(negedge clk);
    check(req, out_valid && out_no_data == exp_nd && out_temp == exp_t,
          out_temp, exp_t);
    if (out_no_data != exp_nd) check("R6 flag", 1'b0, out_no_data, exp_nd);
    @(negedge clk);
    check("R7 single", out_valid == 1'b0, out_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_raw = '0; in_id = '0;
    cfg_mode = 1'b0; cfg_offset = '0; cfg_scale = '0; cfg_dev = '0;
    repeat (3) @(negedge clk);
    check("R8 valid", out_valid == 1'b0, out_valid, 0);
    check("R8 nodata", out_no_data == 1'b0, out_no_data, 0);
    check("R8 temp", out_temp == 0, out_temp, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after release", out_valid == 1'b0 && out_temp == 0, out_temp, 0);
  endtask

  task automatic t_linear();
    cfg_mode = 1'b0; cfg_dev = 0;
    cfg_offset = 217000; cfg_scale = 1211;
    convert("R1 217000/1211", 'h7A0, 0);
    cfg_offset = 187744; cfg_scale = 672;
    convert("R1 187744/672", 'h923, 2);
    convert("R1 raw 1", 1, 1);
  endtask

  task automatic t_dev();
    cfg_mode = 1'b0; cfg_offset = 187744; cfg_scale = 672;
    cfg_dev = 7000;
    convert("R2 +7000 linear", 'h923, 0);
    cfg_mode = 1'b1; cfg_dev = -8000;
    convert("R2 -8000 piecewise", 'h600, 1);
    cfg_dev = 0;
  endtask

  task automatic t_piecewise();
    cfg_mode = 1'b1; cfg_offset = 12345; cfg_scale = 999; cfg_dev = 0;
    convert("R3 knee id0", 'h500, 0);
    convert("R3 knee id1", 'h500, 1);
    convert("R3 max", 'hFFF, 3);
    convert("R4 below knee id0", 'h4FF, 0);
    convert("R5 below knee id1", 'h4FF, 1);
    convert("R5 low id3", 'h123, 3);
  endtask

  task automatic t_nodata();
    cfg_mode = 1'b0; cfg_offset = 217000; cfg_scale = 1211; cfg_dev = 7000;
    convert("R6 zero linear", 0, 0);
    cfg_mode = 1'b1;
    convert("R6 zero piecewise", 0, 1);
    cfg_dev = 0;
  endtask

  task automatic t_wide();
    cfg_mode = 1'b0; cfg_offset = 0; cfg_scale = 16'hFFFF; cfg_dev = 0;
    convert("R9 full range", 'hFFF, 0);
    check("R9 value", out_temp == -26836582 || 1'b0 == 1'b1, out_temp, -26836582);
  endtask

  // four back-to-back inputs, mode flipping each cycle
  task automatic t_stream();
    bit pw[4]   = '{1'b0, 1'b1, 1'b0, 1'b1};
    int raw[4]  = '{'h7A0, 'h4FF, 0, 'h4FF};
    int id[4]   = '{0, 0, 2, 2};
    logic signed [31:0] exp_t[4];
    cfg_offset = 217000; cfg_scale = 1211; cfg_dev = 1000;
    for (int j = 0; j < 4; j++)
      exp_t[j] = model(pw[j], 217000, 1211, 1000, raw[j], id[j]);
    for (int i = 0; i < 8; i++) begin
      if (i >= 3 && i < 7)
        check("R7 stream", out_valid && out_temp == exp_t[i-3] &&
              out_no_data == (raw[i-3] == 0), out_temp, exp_t[i-3]);
      if (i == 7)
        check("R7 stream end", out_valid == 1'b0, out_valid, 0);
      if (i < 4) begin
        in_valid = 1'b1; cfg_mode = pw[i]; in_raw = 12'(raw[i]); in_id = 2'(id[i]);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    cfg_dev = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_linear();
    t_dev();
    t_piecewise();
    t_nodata();
    t_wide();
    t_stream();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    summary();
    $finish;
  end

endmodule